// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block pairs two 8-line priority interrupt controllers. The first (the master) talks to the CPU. The second (the slave) feeds master line 2. Each controller holds three 8-bit registers: pending requests, a mask, and in-service lines. It also holds a current active level and a vector base. A request pulse on one of the 16 global request lines latches a pending bit. Lines 0 to 7 go to the master. Lines 8 to 15 go to the slave as local line n-8, and each of those also marks master line 2 as pending.

Resolution runs only when something could change the outcome: a new request, an end-of-interrupt command, a mask write that touches a pending line, or an acknowledge. It also waits until the CPU interrupt-enable input is high. The winner is the lowest-numbered line that is pending, unmasked and not in service. In the normal nested mode the search stops below the active level. When the master winner is line 2, the slave resolves as well, and both controllers are started in the same cycle. The CPU sees a held interrupt line. It answers with an acknowledge pulse and gets an 8-bit vector one cycle later.

Top module: `cascaded_irq_ctrl`

## Requirements
- R1: After reset, all pending and in-service bits are clear. Both masks are all ones (bit = 1 blocks the line). Both vector bases are 0x00. Both active levels are 8 (none). The outputs int_o, vec_valid and cascade_err are low.
- R2: A line is a candidate when it is pending, unmasked and not in service. The lowest-numbered candidate wins. The vector is the controller's base plus the line number, modulo 256.
- R3: Without special-mask mode, only lines numbered below the active level are searched. With special_mask high, all 8 lines are searched.
- R4: Global request n in 8..15 sets slave pending bit n-8 and master pending bit 2. Requests 0..7 set master pending bit n.
- R5: If the master winner is line 2 and the slave has a candidate, both controllers start their line in the same cycle. The vector is the slave base plus the slave line.
- R6: If the master winner is line 2 and the slave has no candidate, cascade_err pulses for one cycle. No vector is delivered, no in-service bit changes, and master pending bit 2 is dropped.
- R7: Starting a line clears its pending bit. With auto_eoi low, it also sets the in-service bit and makes that line the active level. With auto_eoi high, the in-service bits and the active level are left unchanged.
- R8: int_o never rises while cpu_ie is low. A resolution left pending is carried out once cpu_ie returns high.
- R9: A mask write triggers a new resolution only if a bit it changes belongs to a line that is pending and not in service.
- R10: eoi clears the lowest set in-service bit of the controller chosen by eoi_sel (0 = master, 1 = slave). The active level becomes the next set in-service bit, or 8 if none is left.
- R11: int_o stays high until inta is sampled high. vec_valid and vec_o appear on the following cycle for exactly one cycle. inta while int_o is low has no effect.
- R12: base_we loads base_data into the vector base of the controller chosen by base_sel (0 = master, 1 = slave).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Request pulses, one per global line |
| cpu_ie | input | 1 | CPU interrupt-enable flag |
| inta | input | 1 | Interrupt acknowledge pulse |
| eoi | input | 1 | Non-specific end-of-interrupt command |
| eoi_sel | input | 1 | EOI target: 0 master, 1 slave |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | 1 | Mask target: 0 master, 1 slave |
| mask_data | input | 8 | New mask value |
| base_we | input | 1 | Vector base write strobe |
| base_sel | input | 1 | Base target: 0 master, 1 slave |
| base_data | input | 8 | New vector base |
| auto_eoi | input | 1 | Start lines without marking them in service |
| special_mask | input | 1 | Search all lines regardless of active level |
| int_o | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Interrupt vector |
| cascade_err | output | 1 | Master picked line 2 with no slave candidate |

## Verification
The bench targets the active-level cut-off. A design that searched all lines would deliver a lower-priority line while a higher one is still in service. A design that cut off wrongly would block a higher-priority nested request. Cascade cases check that a slave request is blocked while master line 2 is in service, and that an empty slave raises the error flag instead of producing a vector built from stale state. Mask writes that change nothing, or change only idle lines, must not raise the interrupt. Requests that were suppressed by a low enable must still be delivered later. Auto-EOI must let a queued lower-priority line through with no EOI command, and a design that set the in-service bit anyway would stall it.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int LINES     = 8;
  localparam int LW        = $clog2(LINES);
  localparam int IW        = $clog2(LINES + 1);
  localparam int VW        = 8;
  localparam int CASC_LINE = 2;

  // Lowest set bit of v whose index is below lim; LINES when none.
  function automatic logic [IW-1:0] first_set(input logic [LINES-1:0] v,
                                              input logic [IW-1:0] lim);
    logic [IW-1:0] r;
    r = IW'(LINES);
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i] && (IW'(i) < lim)) r = IW'(i);
    return r;
  endfunction

  function automatic logic [VW-1:0] make_vec(input logic [VW-1:0] base,
                                             input logic [LW-1:0] line);
    return base + VW'(line);
  endfunction
endpackage

// File: rtl/cic_unit.sv
module cic_unit
  import cic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_set,
  input  logic [LINES-1:0] req_drop,
  input  logic             start,
  input  logic [LW-1:0]    start_line,
  input  logic             auto_eoi,
  input  logic             special_mask,
  input  logic             mask_we,
  input  logic [LINES-1:0] mask_data,
  input  logic             base_we,
  input  logic [VW-1:0]    base_data,
  input  logic             eoi,
  output logic             cand_found,
  output logic [LW-1:0]    cand_line,
  output logic [VW-1:0]    base_q,
  output logic             recheck,
  output logic [LINES-1:0] isr_q,
  output logic [IW-1:0]    act_q
);
  logic [LINES-1:0] irr_q, imr_q;
  logic [LINES-1:0] cand, start_bit, eoi_bit, isr_n;
  logic [IW-1:0]    lim, cand_idx, eoi_idx;

  assign cand       = irr_q & ~imr_q & ~isr_q;
  assign lim        = special_mask ? IW'(LINES) : act_q;
  assign cand_idx   = first_set(cand, lim);
  assign cand_found = (cand_idx != IW'(LINES));
  assign cand_line  = cand_idx[LW-1:0];
  assign recheck    = mask_we && |((imr_q ^ mask_data) & irr_q & ~isr_q);

  assign start_bit  = start ? (LINES'(1) << start_line) : '0;
  assign eoi_idx    = first_set(isr_q, IW'(LINES));
  assign eoi_bit    = (eoi && eoi_idx != IW'(LINES)) ? (LINES'(1) << eoi_idx[LW-1:0]) : '0;
  assign isr_n      = (isr_q & ~eoi_bit) | (auto_eoi ? '0 : start_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      imr_q  <= '1;
      isr_q  <= '0;
      act_q  <= IW'(LINES);
      base_q <= '0;
    end else begin
      irr_q <= (irr_q & ~start_bit & ~req_drop) | req_set;
      isr_q <= isr_n;
      if (mask_we) imr_q <= mask_data;
      if (base_we) base_q <= base_data;
      if (start && !auto_eoi) act_q <= IW'(start_line);
      else if (eoi)           act_q <= first_set(isr_n, IW'(LINES));
    end
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q == '0) |-> (act_q == IW'(LINES))); // R10
  AST_AUTO_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && auto_eoi && !eoi) |=> (isr_q == $past(isr_q))); // R7
  AST_START_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !req_set[start_line]) |=> !irr_q[$past(start_line)]); // R7
endmodule

// File: rtl/cic_handshake.sv
module cic_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  input  logic cpu_ie,
  input  logic found,
  input  logic inta,
  output logic int_o,
  output logic ack
);
  logic pend_q, evaluate;

  assign ack      = inta && int_o;
  assign evaluate = pend_q && cpu_ie && !int_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      int_o  <= 1'b0;
    end else begin
      if (trigger || ack) pend_q <= 1'b1;
      else if (evaluate)  pend_q <= 1'b0;
      if (ack)                   int_o <= 1'b0;
      else if (evaluate && found) int_o <= 1'b1;
    end
  end

  AST_INT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && !inta) |=> int_o); // R11
  AST_IE_GATES_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_o) |-> $past(cpu_ie)); // R8
endmodule

// File: rtl/cascaded_irq_ctrl.sv
module cascaded_irq_ctrl
  import cic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LINES-1:0] irq_req,
  input  logic               cpu_ie,
  input  logic               inta,
  input  logic               eoi,
  input  logic               eoi_sel,
  input  logic               mask_we,
  input  logic               mask_sel,
  input  logic [LINES-1:0]   mask_data,
  input  logic               base_we,
  input  logic               base_sel,
  input  logic [VW-1:0]      base_data,
  input  logic               auto_eoi,
  input  logic               special_mask,
  output logic               int_o,
  output logic               vec_valid,
  output logic [VW-1:0]      vec_o,
  output logic               cascade_err
);
  localparam int NCTL = 2;
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC_LINE;

  logic [NCTL-1:0][LINES-1:0] u_req_set, u_req_drop, u_isr;
  logic [NCTL-1:0][LW-1:0]    u_line, u_start_line;
  logic [NCTL-1:0][VW-1:0]    u_base;
  logic [NCTL-1:0][IW-1:0]    u_act;
  logic [NCTL-1:0]            u_found, u_start, u_recheck;

  logic ack, casc_pick, casc_err, deliver, trigger;
  logic [VW-1:0] vec_next;

  assign casc_pick = u_found[0] && (u_line[0] == LW'(CASC_LINE));
  assign casc_err  = ack && casc_pick && !u_found[1];
  assign deliver   = ack && u_found[0] && !casc_err;

  assign u_start[0]      = deliver;
  assign u_start_line[0] = u_line[0];
  assign u_start[1]      = deliver && casc_pick;
  assign u_start_line[1] = u_line[1];

  assign u_req_set[0]  = irq_req[LINES-1:0] | ((|irq_req[2*LINES-1:LINES]) ? CASC_BIT : '0);
  assign u_req_set[1]  = irq_req[2*LINES-1:LINES];
  assign u_req_drop[0] = casc_err ? CASC_BIT : '0;
  assign u_req_drop[1] = '0;

  assign trigger  = (|irq_req) || (|u_recheck) || eoi;
  assign vec_next = casc_pick ? make_vec(u_base[1], u_line[1]) : make_vec(u_base[0], u_line[0]);

  for (genvar g = 0; g < NCTL; g++) begin : g_unit
    cic_unit u_ctl (
      .clk(clk), .rst_n(rst_n),
      .req_set(u_req_set[g]), .req_drop(u_req_drop[g]),
      .start(u_start[g]), .start_line(u_start_line[g]),
      .auto_eoi(auto_eoi), .special_mask(special_mask),
      .mask_we(mask_we && (mask_sel == 1'(g))), .mask_data(mask_data),
      .base_we(base_we && (base_sel == 1'(g))), .base_data(base_data),
      .eoi(eoi && (eoi_sel == 1'(g))),
      .cand_found(u_found[g]), .cand_line(u_line[g]), .base_q(u_base[g]),
      .recheck(u_recheck[g]), .isr_q(u_isr[g]), .act_q(u_act[g])
    );
  end

  cic_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .cpu_ie(cpu_ie),
    .found(u_found[0]), .inta(inta), .int_o(int_o), .ack(ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid   <= 1'b0;
      vec_o       <= '0;
      cascade_err <= 1'b0;
    end else begin
      vec_valid   <= deliver;
      cascade_err <= casc_err;
      if (deliver) vec_o <= vec_next;
    end
  end

  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta && int_o)); // R11
  AST_ERR_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_err |-> !vec_valid); // R6
  AST_ERR_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    casc_err |=> (u_isr == $past(u_isr))); // R6
  AST_CASC_BOTH_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (u_start[1] && !auto_eoi) |=> (u_isr[0][CASC_LINE] && u_isr[1][$past(u_line[1])])); // R5
endmodule

// File: tb/cascaded_irq_ctrl_tb.sv
module cascaded_irq_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [15:0] irq_req = '0;
  logic cpu_ie = 1, inta = 0, eoi = 0, eoi_sel = 0;
  logic mask_we = 0, mask_sel = 0, base_we = 0, base_sel = 0;
  logic [7:0] mask_data = '0, base_data = '0;
  logic auto_eoi = 0, special_mask = 0;
  logic int_o, vec_valid, cascade_err;
  logic [7:0] vec_o;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cascaded_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cpu_ie(cpu_ie), .inta(inta),
    .eoi(eoi), .eoi_sel(eoi_sel), .mask_we(mask_we), .mask_sel(mask_sel),
    .mask_data(mask_data), .base_we(base_we), .base_sel(base_sel),
    .base_data(base_data), .auto_eoi(auto_eoi), .special_mask(special_mask),
    .int_o(int_o), .vec_valid(vec_valid), .vec_o(vec_o), .cascade_err(cascade_err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(logic [15:0] m);
    irq_req = m; tick(); irq_req = '0; tick(3);
  endtask

  task automatic do_eoi(logic sel);
    eoi = 1; eoi_sel = sel; tick(); eoi = 0; tick(3);
  endtask

  task automatic wr_mask(logic sel, logic [7:0] d);
    mask_we = 1; mask_sel = sel; mask_data = d; tick(); mask_we = 0; tick(3);
  endtask

  task automatic wr_base(logic sel, logic [7:0] d);
    base_we = 1; base_sel = sel; base_data = d; tick(); base_we = 0; tick();
  endtask

  task automatic ack_expect(string tag, logic [7:0] exp);
    check({tag, " int before ack"}, int_o, 1);
    inta = 1; tick(); inta = 0;
    check({tag, " vec_valid"}, vec_valid, 1);
    check({tag, " vector"}, vec_o, exp);
    check({tag, " no error"}, cascade_err, 0);
    tick(3);
  endtask

  task automatic t_reset_r1;
    check("R1 int_o after reset", int_o, 0);
    check("R1 vec_valid after reset", vec_valid, 0);
    check("R1 cascade_err after reset", cascade_err, 0);
    pulse_req(16'h0001);
    check("R1 reset mask blocks line 0", int_o, 0);
    wr_mask(0, 8'h00);
    ack_expect("R1 reset base is zero", 8'h00);
    do_eoi(0);
    wr_mask(1, 8'h00);
    wr_base(0, 8'h20);
    wr_base(1, 8'h70);
    check("R1 nothing pending", int_o, 0);
  endtask

  task automatic t_basic_r2;
    pulse_req(16'h0020);
    ack_expect("R2 single line 5", 8'h25);
    do_eoi(0);
    pulse_req(16'h0048);
    ack_expect("R2 lowest of 3 and 6", 8'h23);
    check("R3 line 6 cut off by level 3", int_o, 0);
    do_eoi(0);
    ack_expect("R10 line 6 after eoi", 8'h26);
    do_eoi(0);
  endtask

  task automatic t_nested_r3;
    pulse_req(16'h0010);
    ack_expect("R3 line 4 first", 8'h24);
    pulse_req(16'h0002);
    ack_expect("R3 nested higher line 1", 8'h21);
    do_eoi(0);
    pulse_req(16'h0040);
    check("R10 level back to 4 blocks line 6", int_o, 0);
    do_eoi(0);
    ack_expect("R10 level 8 lets line 6", 8'h26);
    do_eoi(0);
  endtask

  task automatic t_special_r3;
    pulse_req(16'h0008);
    ack_expect("R3 line 3 in service", 8'h23);
    special_mask = 1;
    pulse_req(16'h0020);
    ack_expect("R3 special mask passes line 5", 8'h25);
    do_eoi(0); do_eoi(0);
    special_mask = 0;
    check("R3 idle after special", int_o, 0);
  endtask

  task automatic t_cascade_r5;
    pulse_req(16'h1000);
    ack_expect("R5 global 12 slave line 4", 8'h74);
    pulse_req(16'h0008);
    check("R3 master 3 blocked by level 2", int_o, 0);
    pulse_req(16'h0200);
    check("R4 slave request blocked while master 2 in service", int_o, 0);
    do_eoi(1);
    check("R5 slave eoi alone keeps master level", int_o, 0);
    do_eoi(0);
    ack_expect("R4 global 9 slave line 1", 8'h71);
    do_eoi(1); do_eoi(0);
    ack_expect("R5 master 3 after cascade done", 8'h23);
    do_eoi(0);
  endtask

  task automatic t_error_r6;
    pulse_req(16'h0004);
    check("R6 int raised for empty cascade", int_o, 1);
    inta = 1; tick(); inta = 0;
    check("R6 cascade_err", cascade_err, 1);
    check("R6 no vector", vec_valid, 0);
    tick(3);
    check("R6 request dropped, no re-raise", int_o, 0);
    pulse_req(16'h0002);
    ack_expect("R6 no in-service left behind", 8'h21);
    do_eoi(0);
  endtask

  task automatic t_ie_r8;
    cpu_ie = 0;
    pulse_req(16'h0080);
    tick(4);
    check("R8 no int while disabled", int_o, 0);
    cpu_ie = 1; tick(2);
    ack_expect("R8 delivered after enable", 8'h27);
    do_eoi(0);
  endtask

  task automatic t_mask_r9;
    wr_mask(0, 8'h40);
    pulse_req(16'h0040);
    check("R9 masked line 6 silent", int_o, 0);
    wr_mask(0, 8'h40);
    check("R9 unchanged mask no rerun", int_o, 0);
    wr_mask(0, 8'h41);
    check("R9 idle bit change no rerun", int_o, 0);
    wr_mask(0, 8'h01);
    ack_expect("R9 unmask pending line 6", 8'h26);
    do_eoi(0);
    wr_mask(0, 8'h00);
  endtask

  task automatic t_auto_r7;
    auto_eoi = 1;
    pulse_req(16'h0028);
    ack_expect("R7 auto line 3", 8'h23);
    ack_expect("R7 auto line 5 without eoi", 8'h25);
    pulse_req(16'h0010);
    ack_expect("R7 auto line 4", 8'h24);
    check("R7 request cleared after start", int_o, 0);
    auto_eoi = 0;
  endtask

  task automatic t_ack_base_r11_r12;
    inta = 1; tick(); inta = 0;
    check("R11 stray inta no vector", vec_valid, 0);
    tick();
    wr_base(0, 8'h40);
    pulse_req(16'h0002);
    ack_expect("R12 new master base", 8'h41);
    tick();
    check("R11 vec_valid one cycle", vec_valid, 0);
    do_eoi(0);
    wr_base(1, 8'hF8);
    pulse_req(16'h8000);
    ack_expect("R12 slave base wrap", 8'hFF);
    do_eoi(1); do_eoi(0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1;
    tick(2);
    t_reset_r1();
    t_basic_r2();
    t_nested_r3();
    t_special_r3();
    t_cascade_r5();
    t_error_r6();
    t_ie_r8();
    t_mask_r9();
    t_auto_r7();
    t_ack_base_r11_r12();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule